// File: doc/BRIEF.md
# I2C master byte engine

This block is a single-master I2C controller that a processor steps through one bus event at a time. The processor asks for a START condition, then for each byte a write or a read, and finally a STOP. Each byte is one burst of nine SCL pulses. Eight data bits go out or come in MSB first, and the ninth pulse carries the acknowledge. Both bus lines are open-drain: the block only pulls a line low or lets it go, and it samples SDA through a synchronizer.

A mode register selects the SCL rate through a prescaler and a divider, and holds an interrupt mask. At the end of every nine-pulse burst a done flag is set. If the mask bit allows it, an interrupt request follows. For a write, the acknowledge sampled from the slave is latched. For a read, the processor chooses whether the master acknowledges in the ninth slot. The processor builds the address byte, with the direction in bit 0, and sends it as an ordinary write.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, mode_o is 0, both lines are released (scl_oe_o=0, sda_oe_o=0), busy_o, done_o, irq_o and ack_o are 0, and ready_o is 1.
- R2: A command is given by cmd_valid_i=1 with cmd_i: 0=START, 1=WRITE, 2=READ, 3=STOP. START is accepted only when busy_o=0. While SCL is released, SDA is pulled low, then SCL is pulled low. busy_o rises when the command is accepted.
- R3: During a byte burst, SDA changes only while SCL is low. It never changes while SCL is released.
- R4: A WRITE sends tx_data_i MSB first on eight SCL pulses and releases SDA for the ninth. ack_o latches SDA as sampled at the end of the ninth SCL-high phase (0 means ACK). rx_data_o holds the eight bus bits seen.
- R5: A READ releases SDA for eight pulses and assembles the bits sampled while SCL is high into rx_data_o, MSB first. In the ninth slot it pulls SDA low when ack_send_i was 1 at acceptance, and releases it otherwise.
- R6: STOP releases SCL while SDA is held low, then releases SDA while SCL is high. busy_o falls once the sequence ends, with both lines released.
- R7: Every SCL half-period lasts BASE_DIV * 2^PS * 2^BD clock cycles. PS is mode bits [1:0] and BD is mode bits [3:2].
- R8: done_o sets when the ninth SCL-high phase of a burst ends and clears when any command is accepted. irq_o is done_o gated by mode bit 7.
- R9: WRITE, READ and STOP are accepted only while the bus is held between transfers (ready_o=1, busy_o=1). START is accepted only when idle. Any other command is ignored, and this includes a command arriving in the same cycle that a burst ends.
- R10: A write on mode_we_i stores all eight bits of mode_wdata_i, and they appear on mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_o | output | 8 | Mode register contents |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code (0 START, 1 WRITE, 2 READ, 3 STOP) |
| tx_data_i | input | 8 | Byte to send with WRITE |
| ack_send_i | input | 1 | READ: 1 drives ACK in the ninth slot |
| rx_data_o | output | 8 | Byte assembled from the bus |
| ack_o | output | 1 | Latched ninth-slot SDA value (0 = ACK) |
| done_o | output | 1 | Burst complete flag |
| irq_o | output | 1 | Masked completion interrupt |
| busy_o | output | 1 | High from START acceptance until STOP ends |
| ready_o | output | 1 | No bus phase in progress |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Two things can happen in the same clock edge: the end of a burst, which sets done and frees the engine, and the acceptance of a new command, which clears done and starts a phase. For every rate setting, the bench counts cycles from the observed rise of the ninth SCL pulse. It then presents a WRITE exactly on the edge where that high phase ends. The command must be dropped: done_o must read 1 afterwards, ready_o must stay 1, and no further SCL pulse may appear over four half-periods.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STA_A, ST_STA_B, ST_STA_C, ST_HOLD,
    ST_BIT_LO, ST_BIT_HI, ST_STO_A, ST_STO_B, ST_STO_C
  } state_e;

  typedef struct packed {
    logic       irq_en;
    logic [2:0] spare;
    logic [1:0] bd;
    logic [1:0] ps;
  } mode_t;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= RESET_VAL;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int unsigned BASE_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] ps_i,
  input  logic [1:0] bd_i,
  output logic       tick_o
);
  localparam int unsigned PRE_MAX = 8;
  localparam int unsigned PW      = $clog2(PRE_MAX);
  localparam int unsigned DIV_MAX = BASE_DIV * 8;
  localparam int unsigned DW      = $clog2(DIV_MAX + 1);

  logic [PW-1:0] pcnt_q, pre_lim;
  logic [DW-1:0] dcnt_q, div_lim;
  logic          pre_last;

  always_comb begin
    pre_lim  = PW'((32'd1 << ps_i) - 32'd1);
    div_lim  = DW'((BASE_DIV << bd_i) - 32'd1);
    pre_last = (pcnt_q >= pre_lim);
    tick_o   = en_i && pre_last && (dcnt_q >= div_lim);
  end

  // counters rest at zero between phases so each phase starts a full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (pre_last) begin
      pcnt_q <= '0;
      dcnt_q <= tick_o ? '0 : dcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_valid_i,
  input  cmd_e       cmd_i,
  input  logic [7:0] tx_data_i,
  input  logic       ack_send_i,
  input  logic       sda_i,
  output logic       run_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic [7:0] rx_data_o,
  output logic       ack_o,
  output logic       done_o,
  output logic       busy_o,
  output logic       ready_o
);
  state_e     state_q, state_d;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rd_q, mack_q, ack_q, done_q, scl_q, sda_q;
  logic       start_ok, hold_ok, last_bit, sda_want, scl_low_d;

  assign start_ok = cmd_valid_i && (cmd_i == CMD_START) && (state_q == ST_IDLE);
  assign hold_ok  = cmd_valid_i && (cmd_i != CMD_START) && (state_q == ST_HOLD);
  assign last_bit = (bit_q == 4'd8);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_ok) state_d = ST_STA_A;
      ST_STA_A:  if (tick_i) state_d = ST_STA_B;
      ST_STA_B:  if (tick_i) state_d = ST_STA_C;
      ST_STA_C:  if (tick_i) state_d = ST_HOLD;
      ST_HOLD:   if (hold_ok) state_d = (cmd_i == CMD_STOP) ? ST_STO_A : ST_BIT_LO;
      ST_BIT_LO: if (tick_i) state_d = ST_BIT_HI;
      ST_BIT_HI: if (tick_i) state_d = last_bit ? ST_HOLD : ST_BIT_LO;
      ST_STO_A:  if (tick_i) state_d = ST_STO_B;
      ST_STO_B:  if (tick_i) state_d = ST_STO_C;
      ST_STO_C:  if (tick_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_low_d = (state_d == ST_STA_C) || (state_d == ST_HOLD) ||
                (state_d == ST_BIT_LO) || (state_d == ST_STO_A);
    unique case (state_q)
      ST_STA_B, ST_STA_C, ST_STO_A, ST_STO_B: sda_want = 1'b1;
      ST_HOLD:                                sda_want = sda_q;
      ST_BIT_LO, ST_BIT_HI:
        if (last_bit) sda_want = rd_q & mack_q;
        else          sda_want = ~rd_q & ~sh_q[7];
      default:                                sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_low_d;
      // SDA lags one cycle behind the state so it moves only after SCL is low
      if (state_q != ST_BIT_HI) sda_q <= sda_want;
      if (start_ok || hold_ok) done_q <= 1'b0;
      if (hold_ok && (cmd_i != CMD_STOP)) begin
        sh_q   <= tx_data_i;
        bit_q  <= '0;
        rd_q   <= (cmd_i == CMD_READ);
        mack_q <= ack_send_i;
      end
      if (tick_i && (state_q == ST_BIT_HI)) begin
        if (last_bit) begin
          ack_q  <= sda_i;
          done_q <= 1'b1;
        end else begin
          sh_q  <= {sh_q[6:0], sda_i};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign run_o     = ~ready_o;
  assign busy_o    = (state_q != ST_IDLE);
  assign scl_oe_o  = scl_q;
  assign sda_oe_o  = sda_q;
  assign rx_data_o = sh_q;
  assign ack_o     = ack_q;
  assign done_o    = done_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_pkg::*;
#(
  parameter int unsigned BASE_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  output logic [7:0] mode_o,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic [7:0] tx_data_i,
  input  logic       ack_send_i,
  output logic [7:0] rx_data_o,
  output logic       ack_o,
  output logic       done_o,
  output logic       irq_o,
  output logic       busy_o,
  output logic       ready_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  mode_t mode_q;
  logic  sda_s, tick, run, done;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);

  i2c_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  i2c_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run),
    .ps_i(mode_q.ps), .bd_i(mode_q.bd), .tick_o(tick)
  );

  i2c_byte_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_e'(cmd_i)),
    .tx_data_i(tx_data_i), .ack_send_i(ack_send_i), .sda_i(sda_s),
    .run_o(run), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .rx_data_o(rx_data_o), .ack_o(ack_o), .done_o(done),
    .busy_o(busy_o), .ready_o(ready_o)
  );

  assign done_o = done;
  assign irq_o  = done & mode_q.irq_en;
  assign mode_o = mode_q;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_i,
  input logic sda_oe_i,
  input logic busy_i,
  input logic ready_i,
  input logic done_i,
  input logic irq_i,
  input logic hi_i
);
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i));

  a_r3_sda_still_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i && $past(hi_i)) |-> $stable(sda_oe_i));

  a_r3_scl_high_in_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_i |-> !scl_oe_i);

  a_r8_irq_only_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ready_i && done_i));

  a_r8_done_holds_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (busy_i && scl_oe_i));

  a_r6_stop_ends_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (!scl_oe_i && !sda_oe_i && $past(!scl_oe_i)));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o),
  .busy_i(busy_o), .ready_i(ready_o), .done_i(done_o), .irq_i(irq_o),
  .hi_i(u_fsm.state_q == i2c_pkg::ST_BIT_HI)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  localparam int BASE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0, cmd_valid = 1'b0, ack_send = 1'b0;
  logic [7:0] mode_wd = '0, tx = '0;
  logic [1:0] cmd = '0;
  logic [7:0] mode_o, rx_data;
  logic ack, done, irq, busy, ready, scl_oe, sda_oe, slave_pull;
  wire  sda_line = ~(sda_oe | slave_pull);
  wire  scl_line = ~scl_oe;

  int errs = 0, checks = 0;
  int bitcnt = 99, bits_seen = 0, hi_cnt = 0, hi_min = 0, hi_max = 0;
  int illegal = 0, start_cnt = 0, stop_cnt = 0, last_cmd = 0;
  logic [8:0] capt = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_ready = 1'b1;
  bit rd_mode = 0, slave_ack = 0;
  logic [7:0] rd_byte = '0;

  always #4 clk = ~clk;

  i2c_byte_master #(.BASE_DIV(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .mode_o(mode_o), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .tx_data_i(tx),
    .ack_send_i(ack_send), .rx_data_o(rx_data), .ack_o(ack), .done_o(done),
    .irq_o(irq), .busy_o(busy), .ready_o(ready), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // bus slave: data for reads, acknowledge for writes
  always_comb begin
    if (bitcnt < 8)       slave_pull = rd_mode && !rd_byte[7 - bitcnt];
    else if (bitcnt == 8) slave_pull = !rd_mode && slave_ack;
    else                  slave_pull = 1'b0;
  end

  always @(negedge clk) begin
    if (prev_ready && !ready) begin
      if (last_cmd == 1 || last_cmd == 2) begin
        bitcnt = 0; bits_seen = 0; capt = '0; hi_min = 1000000; hi_max = 0; illegal = 0;
      end else bitcnt = 99;
    end
    if (scl_line && !prev_scl) begin
      hi_cnt = 1;
      capt = {capt[7:0], sda_line};
      if (bitcnt < 9) bits_seen++;
    end else if (scl_line) hi_cnt++;
    if (!scl_line && prev_scl) begin
      if (bitcnt < 9) begin
        if (hi_cnt < hi_min) hi_min = hi_cnt;
        if (hi_cnt > hi_max) hi_max = hi_cnt;
      end
      if (bitcnt < 99) bitcnt++;
    end
    if (scl_line && prev_scl && (sda_line != prev_sda)) begin
      if (bitcnt < 9)     illegal++;
      else if (!sda_line) start_cnt++;
      else                stop_cnt++;
    end
    prev_scl = scl_line; prev_sda = sda_line; prev_ready = ready;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int c, input logic [7:0] d, input bit a);
    last_cmd = c;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'(c); tx = d; ack_send = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mode_o == 8'h00, "R1 mode", mode_o, 0);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    check(!busy && !done && !irq && !ack && ready, "R1 flags",
          {busy, done, irq, ack, ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 16; k++) begin
      int h, sc, pc;
      bit sie, a;
      logic [7:0] wb;
      h   = BASE * (1 << (k % 4)) * (1 << (k / 4));
      sie = (k % 3) != 0;
      // R10 mode write and readback
      @(negedge clk);
      mode_we = 1'b1; mode_wd = {sie, 3'(k + 5), 2'(k / 4), 2'(k % 4)};
      @(negedge clk);
      mode_we = 1'b0;
      check(mode_o == mode_wd, "R10 mode readback", mode_o, mode_wd);

      // R2 start
      sc = start_cnt;
      send(0, 8'h00, 0);
      check(busy, "R2 busy on start", busy, 1);
      wait_ready();
      check(start_cnt == sc + 1, "R2 start seen", start_cnt, sc + 1);
      check(scl_oe && sda_oe, "R2 lines held low", {scl_oe, sda_oe}, 3);

      // R9 start while bus held is ignored
      send(0, 8'h00, 0);
      repeat (4) @(negedge clk);
      check(ready && start_cnt == sc + 1, "R9 start while busy", start_cnt, sc + 1);

      // R4 write, with a mid-burst write that must be ignored (R9)
      wb = 8'(k * 37 + 11);
      slave_ack = k[1]; rd_mode = 0;
      send(1, wb, 0);
      repeat (3) @(negedge clk);
      send(1, ~wb, 0);
      wait_ready();
      check(capt[8:1] == wb, "R4 R9 write bits", capt[8:1], wb);
      check(capt[0] == !slave_ack, "R4 ninth slot released", capt[0], !slave_ack);
      check(ack == !slave_ack, "R4 ack latch", ack, !slave_ack);
      check(rx_data == wb, "R4 bus readback", rx_data, wb);
      check(done, "R8 done after write", done, 1);
      check(irq == sie, "R8 irq mask", irq, sie);
      check(hi_min == h && hi_max == h, "R7 half period", hi_min * 1000 + hi_max, h * 1001);
      check(illegal == 0, "R3 write sda stable", illegal, 0);

      // R5 read, with a write landing on the burst-end edge (R9)
      rd_byte = 8'(k * 91 + 3); rd_mode = 1; a = k[2];
      send(2, 8'h00, a);
      check(!done, "R8 done cleared", done, 0);
      do begin @(negedge clk); #1; end while (bits_seen != 9);
      repeat (h - 1) @(posedge clk);
      last_cmd = 1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 2'd1; tx = 8'hA5;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(ready && done, "R9 same-edge command dropped", {ready, done}, 3);
      check(rx_data == rd_byte, "R5 read data", rx_data, rd_byte);
      check(capt[0] == !a && ack == !a, "R5 master ack", {capt[0], ack}, {!a, !a});
      check(irq == sie, "R8 irq after read", irq, sie);
      repeat (4 * h) @(negedge clk);
      check(bits_seen == 9 && scl_oe, "R9 no extra pulses", bits_seen, 9);
      check(illegal == 0, "R3 read sda stable", illegal, 0);

      // R6 stop
      pc = stop_cnt;
      send(3, 8'h00, 0);
      while (busy) @(negedge clk);
      check(stop_cnt == pc + 1, "R6 stop seen", stop_cnt, pc + 1);
      check(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
      check(!done && !irq, "R8 cleared by stop", {done, irq}, 0);

      // R9 stop while idle is ignored
      send(3, 8'h00, 0);
      repeat (3) @(negedge clk);
      check(!busy && !scl_oe && stop_cnt == pc + 1, "R9 stop while idle", busy, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule